// File: doc/BRIEF.md
# Peak Input Indicator

This block sits after the decimation filter of an oversampled audio converter. It watches the stream of signed decimated samples and keeps two registers: the most positive sample and the most negative sample accepted since the last refresh. Downstream logic can read these registers to judge how loud the recent input has been.

The held values clear themselves on a free-running refresh timer, so they cover only a recent window rather than everything since reset. At the nominal 5.12 MHz sample-domain clock, a full 24-bit count gives a window of about 3.28 s. A programmable limit input shortens the window. Each time the timer expires, the block emits a one-cycle refresh pulse.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high, and a sample is accepted in every cycle in which `smp_valid` is high. The upstream source may therefore present a new sample in every cycle.

Top module: `peak_indicator`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `hold_max` and `hold_min` read 0 and `refresh_pulse` is low. The refresh counter starts from 0.
- R2: `smp_ready` is 1 in every cycle, and a sample is accepted in each cycle in which `smp_valid` is 1.
- R3: The first sample accepted after reset or after a refresh is loaded into both `hold_max` and `hold_min`, whatever its value. Both outputs show it one cycle after acceptance.
- R4: After that first sample, `hold_max` takes an accepted sample only if the sample is strictly greater, and `hold_min` only if it is strictly smaller. Both comparisons treat `smp_data` as 16-bit two's complement (0x8000 is the most negative value, 0x7FFF the most positive). Equal samples and cycles with `smp_valid` low leave both holds unchanged.
- R5: `refresh_pulse` is high for exactly one cycle whenever the counter is greater than or equal to `refresh_limit`, and the counter then restarts from 0. With a constant limit L, pulses therefore occur every L+1 cycles, and the first pulse comes L cycles after reset is released.
- R6: A refresh in a cycle with no valid sample clears both holds to 0 on the next cycle.
- R7: When a refresh and a valid sample occur in the same cycle, the refresh takes priority: the sample becomes both the new maximum and the new minimum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_limit | input | 24 | Terminal count of the refresh timer |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_ready | output | 1 | Always 1; the block never stalls |
| smp_data | input | 16 | Signed decimated sample |
| hold_max | output | 16 | Largest sample in the current window |
| hold_min | output | 16 | Smallest sample in the current window |
| refresh_pulse | output | 1 | One-cycle pulse when the window restarts |

## Verification
The timer assertions assume that `refresh_limit` does not change while reset is released. The check that forbids back-to-back refresh pulses also assumes the limit is nonzero. The bench writes the limit only while `rst` is high and uses only the values 9 and 0xFFFFFF. The hold assertions make no assumption about sample values, so the stimulus deliberately includes both extremes of the signed range, equal repeats, and data that changes while `smp_valid` is low.

// File: rtl/pii_pkg.sv
package pii_pkg;
  localparam int SAMPLE_W_DEF = 16;
  localparam int COUNT_W_DEF  = 24;

  typedef enum logic {TRACK_MAX = 1'b0, TRACK_MIN = 1'b1} track_kind_e;
endpackage

// File: rtl/pii_refresh_timer.sv
module pii_refresh_timer #(
  parameter int COUNT_W = pii_pkg::COUNT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COUNT_W-1:0] limit,
  output logic               tick
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic [COUNT_W-1:0] count_q;

  // Comparing with >= means a limit lowered below the current count still expires at once.
  assign tick = (count_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= '0;
    else           count_q <= count_q + ONE;
  end

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count_q == '0));
  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (count_q == $past(count_q) + ONE));
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && limit != '0) |=> !tick);
endmodule

// File: rtl/pii_hold_reg.sv
module pii_hold_reg #(
  parameter int                   SAMPLE_W = pii_pkg::SAMPLE_W_DEF,
  parameter pii_pkg::track_kind_e KIND     = pii_pkg::TRACK_MAX
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W-1:0] hold
);
  logic armed_q;
  logic beats;

  generate
    if (KIND == pii_pkg::TRACK_MAX) begin : g_cmp_max
      assign beats = (sample > hold);
    end else begin : g_cmp_min
      assign beats = (sample < hold);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      armed_q <= 1'b0;
    end else if (tick) begin
      hold    <= valid ? sample : '0;
      armed_q <= valid;
    end else if (valid) begin
      if (!armed_q || beats) hold <= sample;
      armed_q <= 1'b1;
    end
  end

  p_refresh_take_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && valid) |=> (hold == $past(sample)));
  p_refresh_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !valid) |=> (hold == '0));
  p_first_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && valid && !armed_q) |=> (hold == $past(sample)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !valid) |=> $stable(hold));

  generate
    if (KIND == pii_pkg::TRACK_MAX) begin : g_chk_max
      p_no_retreat_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && armed_q) |=> ($signed(hold) >= $signed($past(hold))));
    end else begin : g_chk_min
      p_no_retreat_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && armed_q) |=> ($signed(hold) <= $signed($past(hold))));
    end
  endgenerate
endmodule

// File: rtl/peak_indicator.sv
module peak_indicator #(
  parameter int SAMPLE_W = pii_pkg::SAMPLE_W_DEF,
  parameter int COUNT_W  = pii_pkg::COUNT_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COUNT_W-1:0]  refresh_limit,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [SAMPLE_W-1:0] hold_max,
  output logic [SAMPLE_W-1:0] hold_min,
  output logic                refresh_pulse
);
  localparam int NUM_TRACK = 2;

  logic                       tick;
  logic                       take;
  logic signed [SAMPLE_W-1:0] held [NUM_TRACK];

  assign smp_ready = 1'b1;
  assign take      = smp_valid && smp_ready;

  pii_refresh_timer #(.COUNT_W(COUNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .limit (refresh_limit),
    .tick  (tick)
  );

  generate
    for (genvar g = 0; g < NUM_TRACK; g++) begin : g_track
      localparam pii_pkg::track_kind_e KIND_G =
        (g == 0) ? pii_pkg::TRACK_MAX : pii_pkg::TRACK_MIN;
      pii_hold_reg #(.SAMPLE_W(SAMPLE_W), .KIND(KIND_G)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .valid  (take),
        .sample ($signed(smp_data)),
        .hold   (held[g])
      );
    end
  endgenerate

  assign hold_max      = held[0];
  assign hold_min      = held[1];
  assign refresh_pulse = tick;

  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    $signed(hold_max) >= $signed(hold_min));
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (hold_max == '0 && hold_min == '0));
endmodule

// File: tb/peak_indicator_test.sv
module peak_indicator_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        v;
    logic [15:0] d;
    logic [15:0] mx;
    logic [15:0] mn;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h7000, 16'h0000, 16'h0000},
    '{1'b1, 16'hFFFB, 16'hFFFB, 16'hFFFB},
    '{1'b1, 16'h0003, 16'h0003, 16'hFFFB},
    '{1'b1, 16'h0003, 16'h0003, 16'hFFFB},
    '{1'b1, 16'hFFFB, 16'h0003, 16'hFFFB},
    '{1'b0, 16'h7FFF, 16'h0003, 16'hFFFB},
    '{1'b1, 16'h8000, 16'h0003, 16'h8000},
    '{1'b1, 16'h7FFF, 16'h7FFF, 16'h8000},
    '{1'b1, 16'h0000, 16'h7FFF, 16'h8000},
    '{1'b1, 16'h8001, 16'h7FFF, 16'h8000},
    '{1'b0, 16'h8000, 16'h7FFF, 16'h8000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] refresh_limit = 24'hFFFFFF;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic [15:0] hold_max, hold_min;
  logic        refresh_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  peak_indicator uut (
    .clk(clk), .rst(rst), .refresh_limit(refresh_limit),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .hold_max(hold_max), .hold_min(hold_min), .refresh_pulse(refresh_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [23:0] lim);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; refresh_limit = lim;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 max", 32'(hold_max), 32'h0);
    check("R1 min", 32'(hold_min), 32'h0);
    check("R1 pulse", 32'(refresh_pulse), 32'h0);
    rst = 1'b0;

    // Vector table: window long enough that no refresh interferes (R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      smp_valid = VECS[i].v;
      smp_data  = VECS[i].d;
      @(negedge clk);
      check("R2 ready", 32'(smp_ready), 32'h1);
      check("R3/R4 max", 32'(hold_max), 32'(VECS[i].mx));
      check("R3/R4 min", 32'(hold_min), 32'(VECS[i].mn));
    end

    // Directed: refresh timing and interaction with samples
    do_reset(24'd9);
    for (int n = 0; n <= 30; n++) begin
      check("R5 pulse", 32'(refresh_pulse), 32'((n % 10) == 9));
      case (n)
        2:  begin smp_valid = 1'b1; smp_data = 16'h1234; end
        3:  smp_data = 16'hFF00;
        4:  smp_valid = 1'b0;
        8:  begin
              check("R3 max pre-refresh", 32'(hold_max), 32'h1234);
              check("R4 min pre-refresh", 32'(hold_min), 32'hFF00);
            end
        10: begin
              check("R6 max cleared", 32'(hold_max), 32'h0);
              check("R6 min cleared", 32'(hold_min), 32'h0);
            end
        12: begin smp_valid = 1'b1; smp_data = 16'hFFF0; end
        13: begin
              smp_valid = 1'b0;
              check("R3 max after refresh", 32'(hold_max), 32'hFFF0);
              check("R3 min after refresh", 32'(hold_min), 32'hFFF0);
            end
        19: begin smp_valid = 1'b1; smp_data = 16'h0042; end
        20: begin
              check("R7 max", 32'(hold_max), 32'h0042);
              check("R7 min", 32'(hold_min), 32'h0042);
              smp_data = 16'h0050;
            end
        21: begin
              smp_valid = 1'b0;
              check("R4 max after R7", 32'(hold_max), 32'h0050);
              check("R4 min after R7", 32'(hold_min), 32'h0042);
            end
        default: ;
      endcase
      @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule